// File: doc/BRIEF.md
# Timing and LVL1 Trigger Pair Checker

The block takes a fast timing-trigger line and a later LVL1 trigger message, and decides whether each trigger arrived as a proper pair. The message is a one-cycle strobe that carries a trigger number and a qualifier saying whether this kind of trigger expects a timing pulse. The timing line first passes through a pulse-width filter. A high pulse shorter than `MIN_PULSE` clocks is counted as a spike and goes no further. A longer pulse opens a pairing sequence in a small state machine.

For every trigger, the state machine reaches a verdict. That verdict can name a missing timing pulse, extra timing pulses, a timeout waiting for the message, or a mismatch between the received number and the block's own trigger number. The verdict sits on flag outputs and in a status byte until the next verdict replaces it. Saturating counters keep statistics on spikes, spurious pulses, invalid triggers, multiple-pulse triggers and the time spent idle, counted in microsecond ticks. A synchronous clear input resets the statistics.

Top module: `trig_pair_checker`

## Requirements
- R1: The state field `status[3:0]` reads 0 in idle, 1 once a valid timing pulse has been seen, 3 after a LVL1 message is accepted with a clean verdict, and 5 after a bad verdict. From 3 or 5 the machine moves to 7 for exactly one clock, with `done` high, and then returns to 0.
- R2: A timing-input high pulse shorter than `MIN_PULSE` clocks adds one to the spike counter and leaves the state at 0. A pulse of `MIN_PULSE` clocks or longer moves the state to 1 and counts no spike.
- R3: A LVL1 message with `l1_needs_tt` high that arrives while no timing pulse has been seen sets `err_missing`, and the state goes to 5.
- R4: A second valid timing pulse before the LVL1 message sets `err_multi`, adds one to the multiple-trigger counter, and the state goes to 5.
- R5: If no LVL1 message arrives within `TIMEOUT_CYC` clocks of entering state 1, the block sets `err_timeout`, the state goes to 5, and the trigger number still advances.
- R6: The internal trigger number `trig_num` is 0 after reset and adds one each time the machine passes through state 7. A LVL1 message whose number differs from `trig_num` sets `err_mismatch`, and the state goes to 5.
- R7: A timing pulse followed by a LVL1 message with `l1_needs_tt` low adds one to the spurious counter. The state goes to 5 and no error flag is set.
- R8: Each verdict that carries at least one error flag adds one to the invalid-trigger counter. A clean verdict does not.
- R9: The four error flags, mirrored in `status[4]` (missing), `status[5]` (multi), `status[6]` (timeout) and `status[7]` (mismatch), hold the latest verdict until the next verdict replaces them.
- R10: The idle-time counter adds one for each `us_tick` seen while the state is 0. A tick in any other state has no effect on it.
- R11: Every statistics counter saturates at its all-ones value.
- R12: A one-cycle `clr` zeroes all statistics counters. It leaves `trig_num` and the error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the statistics counters |
| tt_in | input | 1 | Timing-trigger line, sampled on the system clock |
| l1_valid | input | 1 | One-cycle strobe for a LVL1 trigger message |
| l1_num | input | NUM_W | Trigger number carried by the message |
| l1_needs_tt | input | 1 | High when this trigger type expects a timing pulse |
| us_tick | input | 1 | One-cycle microsecond tick |
| err_missing | output | 1 | Last verdict: timing pulse missing |
| err_multi | output | 1 | Last verdict: more than one timing pulse |
| err_timeout | output | 1 | Last verdict: LVL1 message came too late |
| err_mismatch | output | 1 | Last verdict: trigger number mismatch |
| done | output | 1 | High for the clock spent in state 7 |
| trig_num | output | NUM_W | Internal trigger number |
| cnt_spike | output | CNT_W | Spike counter |
| cnt_spurious | output | CNT_W | Spurious timing pulse counter |
| cnt_invalid | output | CNT_W | Invalid trigger counter |
| cnt_multi | output | CNT_W | Multiple timing pulse counter |
| cnt_idle | output | IDLE_W | Idle time in microsecond ticks |
| status | output | 8 | {mismatch, timeout, multi, missing, state code} |

## Verification
The assertions assume that `l1_valid` and `us_tick` are single-cycle strobes and that the timing line, once sampled, never shows a spike and a valid edge in the same clock. They also assume `TIMEOUT_CYC` is reachable by the timer. The stimulus drives each strobe for exactly one clock on the falling edge, leaves several idle clocks between sequences, and sends each LVL1 message a few clocks after the pulse filter has fired. No message ever lands while the machine sits in state 3, 5 or 7. Widths and delays are swept over small ranges, and the counter widths are reduced so that saturation is reached quickly.

// File: rtl/trig_chk_pkg.sv
package trig_chk_pkg;

  // State codes are fixed: software and neighbours decode the numeric value.
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_TT   = 4'd1,
    ST_L1   = 4'd3,
    ST_BAD  = 4'd5,
    ST_DONE = 4'd7
  } pair_state_e;

  // Packed so that {verdict, state} forms the status byte (missing at bit 4).
  typedef struct packed {
    logic mismatch;
    logic timeout;
    logic multi;
    logic missing;
  } verdict_t;

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)
      q_o <= '0;
    else if (inc_i && (q_o != MAXV))
      q_o <= q_o + 1'b1;
  end

  // R11
  hold_at_max_chk: assert property (@(posedge clk) disable iff (rst)
    (q_o == MAXV && !clr) |=> (q_o == MAXV));

  // R12
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q_o == '0));

endmodule

// File: rtl/tt_shaper.sv
module tt_shaper #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tt_i,
  output logic tt_ok_o,
  output logic spike_o
);

  localparam int RUN_W = $clog2(MIN_PULSE + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_PULSE);
  localparam logic [RUN_W-1:0] RUN_HIT = RUN_W'(MIN_PULSE - 1);

  logic             tt_q;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      tt_q    <= 1'b0;
      run     <= '0;
      tt_ok_o <= 1'b0;
      spike_o <= 1'b0;
    end else begin
      tt_q    <= tt_i;
      tt_ok_o <= tt_q && (run == RUN_HIT);
      spike_o <= !tt_q && (run != '0) && (run < RUN_MAX);
      if (!tt_q)
        run <= '0;
      else if (run != RUN_MAX)
        run <= run + 1'b1;
    end
  end

  // R2
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(tt_ok_o && spike_o));

  // R2
  single_ok_chk: assert property (@(posedge clk) disable iff (rst)
    tt_ok_o |=> !tt_ok_o);

endmodule

// File: rtl/pair_fsm.sv
module pair_fsm
  import trig_chk_pkg::*;
#(
  parameter int TIMEOUT_CYC = 250,
  parameter int NUM_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tt_ok_i,
  input  logic             l1_valid_i,
  input  logic [NUM_W-1:0] l1_num_i,
  input  logic             l1_needs_tt_i,
  output pair_state_e      state_o,
  output verdict_t         verdict_o,
  output logic             verdict_stb_o,
  output logic             spurious_o,
  output logic [NUM_W-1:0] trig_num_o
);

  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LIM = TMR_W'(TIMEOUT_CYC);

  logic [TMR_W-1:0] timer;
  logic             extra;
  verdict_t         idle_v, tt_v, to_v;
  logic             num_bad, idle_spur;

  always_comb begin
    num_bad        = (l1_num_i != trig_num_o);
    idle_spur      = tt_ok_i && !l1_needs_tt_i;
    idle_v         = '0;
    idle_v.missing = l1_needs_tt_i && !tt_ok_i;
    idle_v.mismatch= num_bad;
    tt_v           = '0;
    tt_v.multi     = extra || tt_ok_i;
    tt_v.mismatch  = num_bad;
    to_v           = '0;
    to_v.timeout   = 1'b1;
    to_v.multi     = extra;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o       <= ST_IDLE;
      timer         <= '0;
      extra         <= 1'b0;
      verdict_o     <= '0;
      verdict_stb_o <= 1'b0;
      spurious_o    <= 1'b0;
      trig_num_o    <= '0;
    end else begin
      verdict_stb_o <= 1'b0;
      spurious_o    <= 1'b0;
      unique case (state_o)
        ST_IDLE: begin
          if (l1_valid_i) begin
            verdict_o     <= idle_v;
            verdict_stb_o <= 1'b1;
            spurious_o    <= idle_spur;
            state_o       <= ((|idle_v) || idle_spur) ? ST_BAD : ST_L1;
          end else if (tt_ok_i) begin
            state_o <= ST_TT;
            timer   <= '0;
            extra   <= 1'b0;
          end
        end
        ST_TT: begin
          if (l1_valid_i) begin
            verdict_o     <= tt_v;
            verdict_stb_o <= 1'b1;
            spurious_o    <= !l1_needs_tt_i;
            state_o       <= ((|tt_v) || !l1_needs_tt_i) ? ST_BAD : ST_L1;
          end else if (timer == TMR_LIM) begin
            verdict_o     <= to_v;
            verdict_stb_o <= 1'b1;
            state_o       <= ST_BAD;
          end else begin
            timer <= timer + 1'b1;
            if (tt_ok_i)
              extra <= 1'b1;
          end
        end
        ST_L1, ST_BAD: state_o <= ST_DONE;
        ST_DONE: begin
          state_o    <= ST_IDLE;
          trig_num_o <= trig_num_o + 1'b1;
        end
        default: state_o <= ST_IDLE;
      endcase
    end
  end

  // R1
  done_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_DONE) |-> ($past(state_o) == ST_L1 || $past(state_o) == ST_BAD));

  // R1
  done_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_DONE) |=> (state_o == ST_IDLE));

  // R6
  num_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_DONE) |=> (trig_num_o == $past(trig_num_o) + 1'b1));

  // R5
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_TT) |-> (timer <= TMR_LIM));

  // R9
  verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !verdict_stb_o |-> $stable(verdict_o));

  // R7
  spur_clean_chk: assert property (@(posedge clk) disable iff (rst)
    spurious_o |-> (state_o == ST_BAD));

endmodule

// File: rtl/trig_pair_checker.sv
module trig_pair_checker
  import trig_chk_pkg::*;
#(
  parameter int MIN_PULSE   = 4,
  parameter int TIMEOUT_CYC = 250,
  parameter int NUM_W       = 16,
  parameter int CNT_W       = 16,
  parameter int IDLE_W      = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tt_in,
  input  logic              l1_valid,
  input  logic [NUM_W-1:0]  l1_num,
  input  logic              l1_needs_tt,
  input  logic              us_tick,
  output logic              err_missing,
  output logic              err_multi,
  output logic              err_timeout,
  output logic              err_mismatch,
  output logic              done,
  output logic [NUM_W-1:0]  trig_num,
  output logic [CNT_W-1:0]  cnt_spike,
  output logic [CNT_W-1:0]  cnt_spurious,
  output logic [CNT_W-1:0]  cnt_invalid,
  output logic [CNT_W-1:0]  cnt_multi,
  output logic [IDLE_W-1:0] cnt_idle,
  output logic [7:0]        status
);

  localparam int NCNT = 4;
  localparam int IX_SPIKE = 0;
  localparam int IX_SPUR  = 1;
  localparam int IX_INV   = 2;
  localparam int IX_MULTI = 3;

  logic        tt_ok, spike, vstb, spur;
  pair_state_e st;
  verdict_t    verdict;
  logic [NCNT-1:0]  inc;
  logic [CNT_W-1:0] cq [NCNT];

  tt_shaper #(.MIN_PULSE(MIN_PULSE)) u_shaper (
    .clk     (clk),
    .rst     (rst),
    .tt_i    (tt_in),
    .tt_ok_o (tt_ok),
    .spike_o (spike)
  );

  pair_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC), .NUM_W(NUM_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .tt_ok_i       (tt_ok),
    .l1_valid_i    (l1_valid),
    .l1_num_i      (l1_num),
    .l1_needs_tt_i (l1_needs_tt),
    .state_o       (st),
    .verdict_o     (verdict),
    .verdict_stb_o (vstb),
    .spurious_o    (spur),
    .trig_num_o    (trig_num)
  );

  always_comb begin
    inc           = '0;
    inc[IX_SPIKE] = spike;
    inc[IX_SPUR]  = spur;
    inc[IX_INV]   = vstb && (|verdict);
    inc[IX_MULTI] = vstb && verdict.multi;
  end

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .inc_i (inc[gi]),
      .q_o   (cq[gi])
    );
  end

  sat_counter #(.W(IDLE_W)) u_idle (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .inc_i (us_tick && (st == ST_IDLE)),
    .q_o   (cnt_idle)
  );

  assign cnt_spike    = cq[IX_SPIKE];
  assign cnt_spurious = cq[IX_SPUR];
  assign cnt_invalid  = cq[IX_INV];
  assign cnt_multi    = cq[IX_MULTI];
  assign err_missing  = verdict.missing;
  assign err_multi    = verdict.multi;
  assign err_timeout  = verdict.timeout;
  assign err_mismatch = verdict.mismatch;
  assign done         = (st == ST_DONE);
  assign status       = {verdict, st};

  // R10
  idle_only_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && !clr) |=> $stable(cnt_idle));

  // R2
  spike_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (spike && st == ST_IDLE && !l1_valid) |=> (st == ST_IDLE));

endmodule

// File: tb/trig_pair_checker_bench.sv
module trig_pair_checker_bench;

  localparam int MINP = 3;
  localparam int TOC  = 20;
  localparam int NW   = 8;
  localparam int CW   = 3;
  localparam int IW   = 3;
  localparam int CMAX = (1 << CW) - 1;
  localparam int IMAX = (1 << IW) - 1;

  logic clk = 1'b0;
  logic rst, clr, tt_in, l1_valid, l1_needs_tt, us_tick;
  logic [NW-1:0] l1_num;
  logic err_missing, err_multi, err_timeout, err_mismatch, done;
  logic [NW-1:0] trig_num;
  logic [CW-1:0] cnt_spike, cnt_spurious, cnt_invalid, cnt_multi;
  logic [IW-1:0] cnt_idle;
  logic [7:0] status;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int e_num = 0, e_spike = 0, e_spur = 0, e_inv = 0, e_multi = 0, e_idle = 0;

  always #5 clk = ~clk;

  trig_pair_checker #(.MIN_PULSE(MINP), .TIMEOUT_CYC(TOC), .NUM_W(NW),
                      .CNT_W(CW), .IDLE_W(IW)) u_trig_pair_checker (
    .clk(clk), .rst(rst), .clr(clr), .tt_in(tt_in), .l1_valid(l1_valid),
    .l1_num(l1_num), .l1_needs_tt(l1_needs_tt), .us_tick(us_tick),
    .err_missing(err_missing), .err_multi(err_multi), .err_timeout(err_timeout),
    .err_mismatch(err_mismatch), .done(done), .trig_num(trig_num),
    .cnt_spike(cnt_spike), .cnt_spurious(cnt_spurious), .cnt_invalid(cnt_invalid),
    .cnt_multi(cnt_multi), .cnt_idle(cnt_idle), .status(status)
  );

  function automatic int sat(int v, int m);
    return (v > m) ? m : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int w);
    repeat (w) begin @(negedge clk); tt_in = 1'b1; end
    @(negedge clk); tt_in = 1'b0;
  endtask

  // returns at the negedge after the accepting edge
  task automatic send_l1(int num, bit needs);
    @(negedge clk);
    l1_valid = 1'b1; l1_num = NW'(num); l1_needs_tt = needs;
    @(negedge clk);
    l1_valid = 1'b0;
  endtask

  task automatic flags(string tag, int m, int mu, int t, int mm);
    chk({tag, " missing"}, err_missing, m);
    chk({tag, " multi"}, err_multi, mu);
    chk({tag, " timeout"}, err_timeout, t);
    chk({tag, " mismatch"}, err_mismatch, mm);
    chk({tag, " status flags"}, status[7:4], (mm << 3) | (t << 2) | (mu << 1) | m);
  endtask

  task automatic counters(string tag);
    chk({tag, " spike cnt"}, cnt_spike, e_spike);
    chk({tag, " spurious cnt"}, cnt_spurious, e_spur);
    chk({tag, " invalid cnt"}, cnt_invalid, e_inv);
    chk({tag, " multi cnt"}, cnt_multi, e_multi);
    chk({tag, " idle cnt"}, cnt_idle, e_idle);
  endtask

  task automatic finish_seq(string tag);
    @(negedge clk);
    chk({tag, " state 7"}, status[3:0], 7);
    chk({tag, " done"}, done, 1);
    @(negedge clk);
    chk({tag, " back to 0"}, status[3:0], 0);
    e_num = (e_num + 1) % (1 << NW);
    chk({tag, " trig_num"}, trig_num, e_num);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst = 1; clr = 0; tt_in = 0; l1_valid = 0; l1_num = '0; l1_needs_tt = 0; us_tick = 0;
    wait_cyc(4);
    rst = 0;
    wait_cyc(2);
    // R1 reset state, R6 number starts at 0
    chk("R1 reset state", status[3:0], 0);
    chk("R6 reset trig_num", trig_num, 0);
    chk("R1 reset done", done, 0);
    flags("R9 reset", 0, 0, 0, 0);
    counters("R11 reset");

    // R1 clean pair
    pulse(4); wait_cyc(4);
    chk("R1 state after pulse", status[3:0], 1);
    send_l1(e_num, 1);
    chk("R1 state after clean L1", status[3:0], 3);
    flags("R9 clean", 0, 0, 0, 0);
    finish_seq("R1 clean");

    // R3 missing timing pulse
    wait_cyc(3);
    send_l1(e_num, 1);
    chk("R3 state bad", status[3:0], 5);
    flags("R3", 1, 0, 0, 0);
    e_inv = sat(e_inv + 1, CMAX);
    finish_seq("R3");
    counters("R8 after missing");

    // R4 double pulse
    wait_cyc(3);
    pulse(4); wait_cyc(3); pulse(4); wait_cyc(4);
    send_l1(e_num, 1);
    chk("R4 state bad", status[3:0], 5);
    flags("R4", 0, 1, 0, 0);
    e_inv = sat(e_inv + 1, CMAX); e_multi = sat(e_multi + 1, CMAX);
    finish_seq("R4");
    counters("R4 counters");

    // R5 timeout
    wait_cyc(3);
    pulse(4); wait_cyc(4);
    chk("R5 waiting in 1", status[3:0], 1);
    wait_cyc(TOC + 10);
    chk("R5 returned to 0", status[3:0], 0);
    flags("R5", 0, 0, 1, 0);
    e_num = (e_num + 1) % (1 << NW);
    e_inv = sat(e_inv + 1, CMAX);
    chk("R5 trig_num advanced", trig_num, e_num);
    counters("R5 counters");

    // R6 mismatch
    pulse(4); wait_cyc(4);
    send_l1(e_num + 9, 1);
    chk("R6 state bad", status[3:0], 5);
    flags("R6", 0, 0, 0, 1);
    e_inv = sat(e_inv + 1, CMAX);
    finish_seq("R6");

    // R7 spurious
    wait_cyc(3);
    pulse(4); wait_cyc(4);
    send_l1(e_num, 0);
    chk("R7 state bad", status[3:0], 5);
    flags("R7", 0, 0, 0, 0);
    e_spur = sat(e_spur + 1, CMAX);
    finish_seq("R7");
    counters("R7 counters");

    // R8 trigger type without timing pulse is clean
    wait_cyc(3);
    send_l1(e_num, 0);
    chk("R8 no-tt trigger state", status[3:0], 3);
    finish_seq("R8 no-tt");
    counters("R8 clean no increment");

    // R2 sweep of widths and delays for clean pairs
    for (int w = MINP; w <= MINP + 2; w++) begin
      for (int d = 3; d <= 7; d++) begin
        wait_cyc(2);
        pulse(w); wait_cyc(d);
        chk("R2 long pulse starts", status[3:0], 1);
        send_l1(e_num, 1);
        flags("R9 sweep", 0, 0, 0, 0);
        finish_seq("R1 sweep");
      end
    end
    counters("R2 sweep counters");

    // R2 spikes
    for (int w = 1; w < MINP; w++) begin
      pulse(w); wait_cyc(5);
      e_spike = sat(e_spike + 1, CMAX);
      chk("R2 spike keeps idle", status[3:0], 0);
      chk("R2 spike count", cnt_spike, e_spike);
    end
    chk("R2 spike no number step", trig_num, e_num);

    // R10 idle ticks
    repeat (5) begin @(negedge clk); us_tick = 1; @(negedge clk); us_tick = 0; end
    e_idle = sat(e_idle + 5, IMAX);
    chk("R10 idle ticks", cnt_idle, e_idle);
    pulse(4); wait_cyc(4);
    repeat (3) begin @(negedge clk); us_tick = 1; @(negedge clk); us_tick = 0; end
    chk("R10 ticks outside idle", cnt_idle, e_idle);
    send_l1(e_num, 1);
    finish_seq("R10 pair");
    repeat (4) begin @(negedge clk); us_tick = 1; @(negedge clk); us_tick = 0; end
    e_idle = sat(e_idle + 4, IMAX);
    chk("R11 idle saturates", cnt_idle, e_idle);

    // R11 spike saturation
    repeat (10) begin pulse(1); wait_cyc(3); e_spike = sat(e_spike + 1, CMAX); end
    chk("R11 spike saturates", cnt_spike, CMAX);
    counters("R11 all");

    // R12 clear
    wait_cyc(1);
    send_l1(e_num, 1);
    e_inv = sat(e_inv + 1, CMAX);
    finish_seq("R12 pre");
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    e_spike = 0; e_spur = 0; e_inv = 0; e_multi = 0; e_idle = 0;
    counters("R12 cleared");
    chk("R12 trig_num kept", trig_num, e_num);
    flags("R12 flags kept", 1, 0, 0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule